// File: doc/BRIEF.md
# MDIO Management Command Controller

This block lets host software run management transactions against an external Ethernet PHY through one command register. Software writes a PHY address, a PHY register number, an optional preamble-suppress flag and, for writes, sixteen data bits, and sets a write-go or read-go bit in the same register write. The block then serialises one management frame onto the management clock and data lines. While the frame is on the wire, a busy bit in the register reads as 1. When the frame ends, a sticky completion interrupt is raised.

For a read, the block releases the data line from the turnaround onward. It samples the sixteen bits the PHY returns on rising edges of the management clock and places them in the register's data field. The management clock is the system clock divided by a programmable half-period. Data changes are launched while that clock is low. The host reaches two word addresses through a plain write/read port: address 0 is the command/status word and address 1 is the interrupt word.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After synchronous reset, the command word (address 0) and the interrupt word (address 1) read 0, `irq` is 0, `mdc` is 0 and `mdio_oe` is 0. Whenever no frame is running, `mdc` and `mdio_oe` stay 0.
- R2: A write frame presents these bits on successive `mdc` rising edges: 32 ones, start `01`, opcode `01`, the 5-bit PHY address (command bits [25:21]), the 5-bit register number (bits [20:16]), turnaround `10`, then data bits [15:0], most significant first. `mdio_oe` is 1 throughout. The frame has 64 rising edges.
- R3: When the preamble-suppress bit (bit 28) is 1, the 32 ones are omitted and the frame has 32 rising edges.
- R4: A read frame uses opcode `10`. `mdio_oe` is 1 only up to the end of the register number and is 0 for the turnaround and the data bits. The 16 bits on `mdio_i` at the last 16 rising edges are stored into bits [15:0], first bit into bit 15.
- R5: The busy bit (bit 29) reads 1 for exactly 2·H·N system clock cycles, counted from the edge that accepts the command, where H is the effective half-period and N is the frame's bit count.
- R6: Each `mdc` half period lasts `half_period` system clocks, and a value of 0 acts as 1. `mdio_o` changes only while `mdc` is low.
- R7: Completion of a frame sets a sticky interrupt that drives `irq` and reads as bit 0 of address 1. Writing 1 to that bit clears it, and writing 0 leaves it set.
- R8: A write to address 0 while busy is 1 is ignored. No new frame starts and the stored fields are unchanged.
- R9: If both go bits (bit 31 write, bit 30 read) are 1, a write frame is sent. Both go bits always read 0.
- R10: An accepted write to address 0 stores the suppress flag, PHY address, register number and data. These read back unchanged after a write frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Host write strobe |
| reg_addr | input | 1 | Host word address (0 command, 1 interrupt) |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for `reg_addr` |
| irq | output | 1 | Sticky completion interrupt |
| half_period | input | DIV_W | MDC half period in system clocks |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input from the PHY |

## Verification
The bench builds the block with the default DIV_W of 8. It drives `half_period` with 0, 1, 2 and 3, so the exact busy length is checked for several divider settings, including the zero-treated-as-one case. Small half-periods keep full 64-bit frames short. That allows many random commands, with and without preamble, to run alongside directed cases: a command written mid-frame, both go bits set, and the interrupt write-one-to-clear.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_BITS   = 32;
    localparam int BODY_BITS  = 32;
    localparam int FRAME_MAX  = PRE_BITS + BODY_BITS;
    localparam int IDX_W      = $clog2(FRAME_MAX + 1);
    localparam int ADR_W      = 5;
    localparam int DAT_W      = 16;
    localparam int HDR_BITS   = 14;

    localparam int B_WGO  = 31;
    localparam int B_RGO  = 30;
    localparam int B_BUSY = 29;
    localparam int B_NPRE = 28;
    localparam int B_PHY  = 21;
    localparam int B_REG  = 16;

    typedef enum logic [1:0] {
        OP_WR = 2'b01,
        OP_RD = 2'b10
    } mdio_op_e;

    typedef struct packed {
        logic             no_pre;
        logic [ADR_W-1:0] phy;
        logic [ADR_W-1:0] regn;
        logic [DAT_W-1:0] data;
    } mdio_fields_t;

    typedef struct packed {
        logic         is_read;
        mdio_fields_t f;
    } mdio_cmd_t;

    function automatic logic [IDX_W-1:0] frame_len(input logic no_pre);
        return no_pre ? IDX_W'(BODY_BITS) : IDX_W'(FRAME_MAX);
    endfunction

    function automatic logic [IDX_W-1:0] drive_len(input mdio_cmd_t c);
        logic [IDX_W-1:0] pre;
        pre = c.f.no_pre ? '0 : IDX_W'(PRE_BITS);
        return c.is_read ? pre + IDX_W'(HDR_BITS) : frame_len(c.f.no_pre);
    endfunction

    function automatic logic [FRAME_MAX-1:0] build_frame(input mdio_cmd_t c);
        logic [BODY_BITS-1:0] body;
        mdio_op_e op;
        op   = c.is_read ? OP_RD : OP_WR;
        body = {2'b01, op, c.f.phy, c.f.regn, 2'b10, c.f.data};
        if (c.f.no_pre)
            return {body, {PRE_BITS{1'b0}}};
        return {{PRE_BITS{1'b1}}, body};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] half_period,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;
    logic             tick;

    assign limit = (half_period == '0) ? '0 : half_period - 1'b1;
    assign tick  = en && (cnt == limit);
    assign rise  = tick && !mdc;
    assign fall  = tick && mdc;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  mdio_cmd_t        cmd,
    input  logic             rise,
    input  logic             fall,
    input  logic             mdio_i,
    output logic             running,
    output logic             mdio_o,
    output logic             mdio_oe,
    output logic             done,
    output logic             done_read,
    output logic [DAT_W-1:0] rx_data
);
    logic [FRAME_MAX-1:0] shift_q;
    logic [IDX_W-1:0]     idx_q;
    logic [IDX_W-1:0]     len_q;
    logic [IDX_W-1:0]     drv_q;
    logic                 read_q;
    logic                 last_bit;
    logic                 in_data;

    assign last_bit  = (idx_q == len_q - 1'b1);
    assign in_data   = read_q && (idx_q >= drv_q + IDX_W'(2));
    assign done      = running && fall && last_bit;
    assign done_read = read_q;
    assign mdio_o    = shift_q[FRAME_MAX-1];
    assign mdio_oe   = running && (idx_q < drv_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            idx_q   <= '0;
            len_q   <= '0;
            drv_q   <= '0;
            read_q  <= 1'b0;
            running <= 1'b0;
            rx_data <= '0;
        end else if (start) begin
            shift_q <= build_frame(cmd);
            idx_q   <= '0;
            len_q   <= frame_len(cmd.f.no_pre);
            drv_q   <= drive_len(cmd);
            read_q  <= cmd.is_read;
            running <= 1'b1;
        end else if (running) begin
            if (rise && in_data)
                rx_data <= {rx_data[DAT_W-2:0], mdio_i};
            if (fall) begin
                if (last_bit) begin
                    running <= 1'b0;
                end else begin
                    idx_q   <= idx_q + 1'b1;
                    shift_q <= {shift_q[FRAME_MAX-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic             reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             busy,
    input  logic             done,
    input  logic             done_read,
    input  logic [DAT_W-1:0] rx_data,
    output logic             start,
    output mdio_cmd_t        cmd,
    output mdio_fields_t     held,
    output logic             irq
);
    logic accept;

    assign accept = reg_we && !reg_addr && !busy;
    assign start  = accept && (reg_wdata[B_WGO] || reg_wdata[B_RGO]);

    always_comb begin
        cmd.is_read = !reg_wdata[B_WGO] && reg_wdata[B_RGO];
        cmd.f.no_pre = reg_wdata[B_NPRE];
        cmd.f.phy    = reg_wdata[B_PHY +: ADR_W];
        cmd.f.regn   = reg_wdata[B_REG +: ADR_W];
        cmd.f.data   = reg_wdata[DAT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            irq  <= 1'b0;
        end else begin
            if (accept)
                held <= cmd.f;
            else if (done && done_read)
                held.data <= rx_data;
            if (done)
                irq <= 1'b1;
            else if (reg_we && reg_addr && reg_wdata[0])
                irq <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr) begin
            reg_rdata[0] = irq;
        end else begin
            reg_rdata[B_BUSY]             = busy;
            reg_rdata[B_NPRE]             = held.no_pre;
            reg_rdata[B_PHY +: ADR_W]     = held.phy;
            reg_rdata[B_REG +: ADR_W]     = held.regn;
            reg_rdata[DAT_W-1:0]          = held.data;
        end
    end
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic             reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             irq,
    input  logic [DIV_W-1:0] half_period,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    logic             busy;
    logic             start;
    logic             rise;
    logic             fall;
    logic             seq_done;
    logic             seq_read;
    logic [DAT_W-1:0] rx_data;
    mdio_cmd_t        cmd;
    mdio_fields_t     held;
    logic [ADR_W-1:0] held_phy;
    logic [ADR_W-1:0] held_reg;

    assign held_phy = held.phy;
    assign held_reg = held.regn;

    mdio_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .done      (seq_done),
        .done_read (seq_read),
        .rx_data   (rx_data),
        .start     (start),
        .cmd       (cmd),
        .held      (held),
        .irq       (irq)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk         (clk),
        .rst         (rst),
        .en          (busy),
        .half_period (half_period),
        .mdc         (mdc),
        .rise        (rise),
        .fall        (fall)
    );

    mdio_frame_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmd       (cmd),
        .rise      (rise),
        .fall      (fall),
        .mdio_i    (mdio_i),
        .running   (busy),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (seq_done),
        .done_read (seq_read),
        .rx_data   (rx_data)
    );
endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
module mdio_cmd_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        irq,
    input logic        reg_we,
    input logic        reg_addr,
    input logic [31:0] reg_wdata,
    input logic        seq_done,
    input logic [4:0]  held_phy,
    input logic [4:0]  held_reg
);
    // R1: idle lines stay quiet
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe));

    // R6: data is launched only while the management clock is low
    p_launch_low_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdio_o) |-> !mdc);

    // R7: interrupt holds until a write-one clear
    p_irq_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (irq && !(reg_we && reg_addr && reg_wdata[0])) |=> irq);

    // R7: end of a frame raises the interrupt
    p_done_irq_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> irq);

    // R8: stored addresses do not move during a frame
    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !seq_done) |=> ($stable(held_phy) && $stable(held_reg)));
endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .irq       (irq),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .seq_done  (seq_done),
    .held_phy  (held_phy),
    .held_reg  (held_reg)
);

// File: tb/sim_mdio_cmd_ctrl.sv
module sim_mdio_cmd_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic [7:0]  half_period = 8'd1;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b0;

    int checks = 0;
    int errors = 0;

    int   rcnt = 0;
    bit   rec_oe [64];
    bit   rec_o  [64];
    logic [15:0] phy_val = '0;
    int   dstart = 64;

    always #2 clk = !clk;

    mdio_cmd_ctrl u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .half_period(half_period), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // simple PHY responder
    always @(posedge mdc) begin
        if (rcnt < 64) begin
            rec_oe[rcnt] = mdio_oe;
            rec_o[rcnt]  = mdio_o;
        end
        rcnt = rcnt + 1;
    end

    always @(negedge mdc) begin
        if (rcnt >= dstart && rcnt < dstart + 16)
            mdio_i = phy_val[15 - (rcnt - dstart)];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic host_read(input logic a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] cmd_word(input bit wg, input bit rg, input bit np,
                                             input logic [4:0] pa, input logic [4:0] ra,
                                             input logic [15:0] d);
        return {wg, rg, 1'b0, np, 2'b00, pa, ra, d};
    endfunction

    function automatic logic [63:0] exp_frame(input bit rd, input bit np,
                                              input logic [4:0] pa, input logic [4:0] ra,
                                              input logic [15:0] d);
        logic [31:0] body;
        body = {2'b01, rd ? 2'b10 : 2'b01, pa, ra, 2'b10, d};
        return np ? {body, 32'h0} : {32'hFFFF_FFFF, body};
    endfunction

    task automatic run_cmd(input bit wg, input bit rg, input bit np,
                           input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] d, input logic [15:0] pv,
                           input logic [7:0] h);
        logic [31:0] rv;
        logic [63:0] ef;
        bit   rd;
        int   n, len, hh, pre, bad_o, bad_oe;
        rd  = !wg && rg;
        len = np ? 32 : 64;
        pre = np ? 0 : 32;
        hh  = (h == 0) ? 1 : h;
        half_period = h;
        phy_val = pv;
        dstart  = rd ? pre + 16 : 64;
        rcnt = 0;
        ef = exp_frame(rd, np, pa, ra, d);

        host_write(1'b0, cmd_word(wg, rg, np, pa, ra, d));
        reg_addr = 1'b0;
        #1;
        n = 0;
        while (reg_rdata[29] && n < 10000) begin
            n++;
            @(negedge clk);
            #1;
        end
        chk("R5 busy cycles", n, 2 * hh * len);
        chk(np ? "R3 rising edge count" : "R2 rising edge count", rcnt, len);

        bad_o = 0;
        bad_oe = 0;
        for (int i = 0; i < len; i++) begin
            bit eoe;
            eoe = rd ? (i < pre + 14) : 1'b1;
            if (rec_oe[i] != eoe) bad_oe++;
            if (eoe && rec_o[i] != ef[63 - i]) bad_o++;
        end
        chk(rd ? "R4 output enable pattern" : "R2 output enable pattern", bad_oe, 0);
        chk(wg && rg ? "R9 frame bits" : (rd ? "R4 header bits" : "R2 frame bits"), bad_o, 0);

        chk("R7 irq after frame", irq, 1'b1);
        host_read(1'b0, rv);
        chk("R9 go bits read 0", rv[31:30], 2'b00);
        chk(rd ? "R4 read data captured" : "R10 fields read back",
            rv, {4'b0, np, 2'b00, pa, ra, rd ? pv : d});

        host_write(1'b1, 32'h1);
        host_read(1'b1, rv);
        chk("R7 irq cleared by write 1", rv, 32'h0);
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        int saved;
        void'($urandom(32'd20240611));

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1 reset state
        host_read(1'b0, rv);
        chk("R1 command word after reset", rv, 32'h0);
        host_read(1'b1, rv);
        chk("R1 interrupt word after reset", rv, 32'h0);
        chk("R1 irq after reset", irq, 1'b0);
        chk("R1 mdc/oe after reset", {mdc, mdio_oe}, 2'b00);

        // R2 write with preamble, R5/R6 divider 2
        run_cmd(1, 0, 0, 5'h13, 5'h0A, 16'hBEEF, 16'h0, 8'd2);
        // R3 suppressed preamble with divider 0 (acts as 1, R6)
        run_cmd(1, 0, 1, 5'h01, 5'h1F, 16'h8001, 16'h0, 8'd0);
        // R4 read
        run_cmd(0, 1, 0, 5'h1F, 5'h00, 16'h0000, 16'hA5C3, 8'd1);
        run_cmd(0, 1, 1, 5'h00, 5'h11, 16'h1234, 16'h5A3C, 8'd3);
        // R9 both go bits
        run_cmd(1, 1, 1, 5'h0C, 5'h03, 16'h0F0F, 16'hFFFF, 8'd1);

        // R8 command during busy ignored
        half_period = 8'd1;
        rcnt = 0;
        dstart = 64;
        host_write(1'b0, cmd_word(1, 0, 0, 5'h05, 5'h06, 16'h7777));
        repeat (40) @(negedge clk);
        host_write(1'b0, cmd_word(0, 1, 1, 5'h1A, 5'h1B, 16'h1111));
        reg_addr = 1'b0;
        #1;
        while (reg_rdata[29]) begin
            @(negedge clk);
            #1;
        end
        saved = rcnt;
        repeat (200) @(negedge clk);
        chk("R8 no second frame", rcnt, 64);
        chk("R8 no extra edges", rcnt, saved);
        host_read(1'b0, rv);
        chk("R8 fields unchanged", rv, {4'b0, 1'b0, 2'b00, 5'h05, 5'h06, 16'h7777});

        // R7 writing 0 keeps irq
        host_write(1'b1, 32'h0);
        host_read(1'b1, rv);
        chk("R7 write 0 keeps irq", rv, 32'h1);
        host_write(1'b1, 32'h1);
        host_read(1'b1, rv);
        chk("R7 write 1 clears irq", rv, 32'h0);

        // R10 field write without go bits starts nothing
        rcnt = 0;
        host_write(1'b0, cmd_word(0, 0, 1, 5'h09, 5'h0B, 16'hC0DE));
        repeat (20) @(negedge clk);
        host_read(1'b0, rv);
        chk("R10 fields stored without go", rv, {4'b0, 1'b1, 2'b00, 5'h09, 5'h0B, 16'hC0DE});
        chk("R10 no frame without go", rcnt, 0);

        // random commands
        for (int k = 0; k < 14; k++) begin
            bit wg, rg, np;
            wg = $urandom % 2;
            rg = wg ? ($urandom % 4 == 0) : 1'b1;
            np = $urandom % 2;
            run_cmd(wg, rg, np, 5'($urandom), 5'($urandom), 16'($urandom),
                    16'($urandom), 8'($urandom % 4));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule